// File: doc/BRIEF.md
# DMX512 Single-Slot Receiver

This block sits after a byte-level serial receiver running at 250 kbaud with 8 data bits. That receiver hands over each byte with two flags: framing error and overrun. The block follows the position of each byte inside a DMX512 packet. A framing error marks the break that opens a packet. The block then checks the start code and counts slots. It captures the value of the single slot whose number equals a 9-bit address. On each capture it raises a one-cycle strobe.

The address comes from two groups of active-low switches: a five-bit group for the low bits and a four-bit group for the high bits. The block takes a new copy of the address at every break. An overrun, or a start code other than zero, puts the block in a state where it waits for the next break and discards every byte until then. A status LED toggles after every sixteen breaks. A combinational flag shows when the switches select address zero, so that logic further along can switch to local control.

Top module: `dmx_slot_sel`

## Requirements
- R1: After reset the block waits for a break, so it ignores bytes received before the first framing error. After reset the strobe is low, the captured value is 0x00 and the LED is high.
- R2: A byte with the overrun flag set puts the block in the waiting state, even if its framing-error flag is also set. Every byte after it is ignored until a byte arrives with the framing error set and the overrun clear. An overrun byte does not step the LED counter.
- R3: A byte with the framing error set and the overrun clear is a break. A break clears the slot count and the capture flag and puts the block in the receiving state. The data of the break byte is discarded.
- R4: The first byte after a break is slot 0, the start code. A value of 0x00 lets counting continue. Any other value sends the block to the waiting state.
- R5: When a byte's slot number equals the stored address, its data appears on `chan_value` one clock after the byte is accepted. In that same cycle `chan_strobe` is high for exactly one clock.
- R6: Only one slot is captured per packet. Bytes at lower slots, and every byte after the capture, leave `chan_value` and `chan_strobe` unchanged.
- R7: The stored address is the bitwise inverse of {`sw_hi_n`[3:0], `sw_lo_n`[4:0]}, with `sw_hi_n` as bits 8..5. It is sampled only at a break, so switch changes inside a packet do not take effect until the next break.
- R8: The slot counter is 10 bits wide and stops at 512. A packet with more than 512 slots still gives exactly one capture, and the next break works as usual.
- R9: A 5-bit counter counts breaks. `led` is high while the count is 0 to 15 and low while it is 16 to 31. After 32 breaks the count returns to 0.
- R10: `addr_zero` is high, combinationally, exactly when the live switch inputs select address 0.
- R11: With address 0 no slot is ever captured, because slot 0 is always treated as the start code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle pulse: a received byte is present |
| rx_data | input | 8 | Received byte |
| rx_ferr | input | 1 | Framing error for this byte (break) |
| rx_ovr | input | 1 | Overrun for this byte |
| sw_lo_n | input | 5 | Active-low address switches, bits 4..0 |
| sw_hi_n | input | 4 | Active-low address switches, bits 8..5 |
| chan_value | output | 8 | Last captured slot value |
| chan_strobe | output | 1 | One-cycle pulse when a new value is captured |
| led | output | 1 | Status LED, blinks on breaks |
| addr_zero | output | 1 | Switches select address 0 |

## Verification
The assertions check on every cycle that:
- an overrun forces the waiting state;
- a break clears the count and sets the receiving state;
- the strobe never lasts two cycles and never fires while waiting or after a capture;
- the slot count stays at or below 512;
- the stored address and the LED change only at breaks.

The bench alone can show that the right slot is chosen and that its value is correct. It sweeps addresses 1 to 64 and the top of the range, and adds the scenarios for overrun, a bad start code, switch changes inside a packet, address zero, packets over 512 slots and the LED phase over more than 32 breaks.

// File: rtl/dmx_sel_pkg.sv
package dmx_sel_pkg;
  typedef enum logic [0:0] {
    ST_WAIT = 1'b0,
    ST_RUN  = 1'b1
  } rx_state_e;
endpackage

// File: rtl/dmx_rst_sync.sv
module dmx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dmx_addr_map.sv
module dmx_addr_map #(
  parameter int ADDR_W = 9,
  parameter int LO_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LO_W-1:0]    sw_lo_n,
  input  logic [ADDR_W-LO_W-1:0] sw_hi_n,
  input  logic               load,
  output logic [ADDR_W-1:0]  addr_q,
  output logic               addr_zero
);
  logic [ADDR_W-1:0] addr_live;
  logic [ADDR_W-1:0] addr_d;

  assign addr_live = ~{sw_hi_n, sw_lo_n};
  assign addr_zero = (addr_live == '0);

  always_comb begin
    addr_d = addr_q;
    if (load) addr_d = addr_live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  // R7: stored address only moves at a break
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(addr_q));
endmodule

// File: rtl/dmx_slot_fsm.sv
module dmx_slot_fsm
  import dmx_sel_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              byte_ferr,
  input  logic              byte_ovr,
  input  logic [ADDR_W-1:0] addr,
  output logic              brk,
  output logic [DATA_W-1:0] value_q,
  output logic              strobe_q
);
  localparam int SLOT_W = ADDR_W + 1;
  localparam logic [SLOT_W-1:0] SLOT_MAX = SLOT_W'(1) << ADDR_W;

  rx_state_e          state_q, state_d;
  logic [SLOT_W-1:0]  cnt_q, cnt_d;
  logic               cap_q, cap_d;
  logic [DATA_W-1:0]  value_d;
  logic               strobe_d;

  assign brk = byte_valid && byte_ferr && !byte_ovr;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    cap_d    = cap_q;
    value_d  = value_q;
    strobe_d = 1'b0;
    if (byte_valid) begin
      if (byte_ovr) begin
        state_d = ST_WAIT;
      end else if (byte_ferr) begin
        state_d = ST_RUN;
        cnt_d   = '0;
        cap_d   = 1'b0;
      end else if (state_q == ST_RUN) begin
        if (cnt_q == '0) begin
          if (byte_data != '0) state_d = ST_WAIT;
          else                 cnt_d   = SLOT_W'(1);
        end else begin
          if (!cap_q && (cnt_q == {1'b0, addr})) begin
            value_d  = byte_data;
            strobe_d = 1'b1;
            cap_d    = 1'b1;
          end
          if (cnt_q != SLOT_MAX) cnt_d = cnt_q + SLOT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_WAIT;
      cnt_q    <= '0;
      cap_q    <= 1'b0;
      value_q  <= '0;
      strobe_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      cap_q    <= cap_d;
      value_q  <= value_d;
      strobe_q <= strobe_d;
    end
  end

  // R2: overrun forces waiting state
  a_r2_overrun_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_ovr) |=> (state_q == ST_WAIT));
  // R2: nothing captured while waiting
  a_r2_wait_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |=> !strobe_q);
  // R3: break clears count and capture flag
  a_r3_break_clears: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> (state_q == ST_RUN && cnt_q == '0 && !cap_q));
  // R5: strobe lasts one cycle
  a_r5_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);
  // R6: one capture per packet
  a_r6_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_q |=> !strobe_q);
  // R8: slot counter never passes its ceiling
  a_r8_slot_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SLOT_MAX);
endmodule

// File: rtl/dmx_blink.sv
module dmx_blink #(
  parameter int BLINK_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic brk,
  output logic led
);
  logic [BLINK_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (brk) cnt_d = cnt_q + BLINK_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign led = ~cnt_q[BLINK_W-1];

  // R9: LED changes only on a break
  a_r9_led_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !brk |=> $stable(led));
endmodule

// File: rtl/dmx_slot_sel.sv
module dmx_slot_sel #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 9,
  parameter int LO_W    = 5,
  parameter int BLINK_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_valid,
  input  logic [DATA_W-1:0]      rx_data,
  input  logic                   rx_ferr,
  input  logic                   rx_ovr,
  input  logic [LO_W-1:0]        sw_lo_n,
  input  logic [ADDR_W-LO_W-1:0] sw_hi_n,
  output logic [DATA_W-1:0]      chan_value,
  output logic                   chan_strobe,
  output logic                   led,
  output logic                   addr_zero
);
  logic              rst_n_s;
  logic              brk;
  logic [ADDR_W-1:0] addr_q;

  dmx_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  dmx_addr_map #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .sw_lo_n   (sw_lo_n),
    .sw_hi_n   (sw_hi_n),
    .load      (brk),
    .addr_q    (addr_q),
    .addr_zero (addr_zero)
  );

  dmx_slot_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .byte_valid (rx_valid),
    .byte_data  (rx_data),
    .byte_ferr  (rx_ferr),
    .byte_ovr   (rx_ovr),
    .addr       (addr_q),
    .brk        (brk),
    .value_q    (chan_value),
    .strobe_q   (chan_strobe)
  );

  dmx_blink #(.BLINK_W(BLINK_W)) u_blink (
    .clk   (clk),
    .rst_n (rst_n_s),
    .brk   (brk),
    .led   (led)
  );
endmodule

// File: tb/sim_dmx_slot_sel.sv
module sim_dmx_slot_sel;
  logic       clk;
  logic       rst_n;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_ferr;
  logic       rx_ovr;
  logic [4:0] sw_lo_n;
  logic [3:0] sw_hi_n;
  logic [7:0] chan_value;
  logic       chan_strobe;
  logic       led;
  logic       addr_zero;

  int checks = 0;
  int errors = 0;
  int breaks = 0;
  int stb_cnt = 0;
  logic [7:0] stb_val = 8'h00;
  bit done = 0;

  dmx_slot_sel u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ferr(rx_ferr), .rx_ovr(rx_ovr), .sw_lo_n(sw_lo_n), .sw_hi_n(sw_hi_n),
    .chan_value(chan_value), .chan_strobe(chan_strobe), .led(led),
    .addr_zero(addr_zero)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] slot_val(input int s, input int salt);
    return 8'((s * 37 + salt * 11 + 5) & 255);
  endfunction

  task automatic set_addr(input int a);
    sw_lo_n = ~5'(a);
    sw_hi_n = ~4'(a >> 5);
  endtask

  task automatic send(input logic [7:0] d, input logic fe, input logic ov);
    @(negedge clk);
    rx_valid = 1; rx_data = d; rx_ferr = fe; rx_ovr = ov;
    @(negedge clk);
    rx_valid = 0; rx_ferr = 0; rx_ovr = 0;
    if (chan_strobe) begin stb_cnt++; stb_val = chan_value; end
  endtask

  task automatic send_break();
    send(8'hA5, 1, 0);
    breaks++;
    chk(led == (((breaks % 32) < 16) ? 1'b1 : 1'b0), "R9 led", int'(led),
        ((breaks % 32) < 16) ? 1 : 0);
  endtask

  task automatic packet(input int nslots, input logic [7:0] sc, input int salt);
    stb_cnt = 0;
    send_break();
    send(sc, 0, 0);
    for (int s = 1; s <= nslots; s++) send(slot_val(s, salt), 0, 0);
  endtask

  task automatic expect_capture(input string req, input int a, input int nslots, input int salt);
    packet(nslots, 8'h00, salt);
    chk(stb_cnt == 1, req, stb_cnt, 1);
    chk(stb_val == slot_val(a, salt), req, int'(stb_val), int'(slot_val(a, salt)));
    chk(chan_value == slot_val(a, salt), req, int'(chan_value), int'(slot_val(a, salt)));
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rx_valid = 0; rx_data = 0; rx_ferr = 0; rx_ovr = 0;
    set_addr(1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(chan_strobe == 0, "R1 strobe", int'(chan_strobe), 0);
    chk(chan_value == 0, "R1 value", int'(chan_value), 0);
    chk(led == 1, "R1 led", int'(led), 1);
    // R1 bytes before first break ignored
    stb_cnt = 0;
    send(8'h00, 0, 0); send(8'h77, 0, 0); send(8'h66, 0, 0);
    chk(stb_cnt == 0, "R1 pre-break bytes", stb_cnt, 0);
    chk(chan_value == 0, "R1 pre-break value", int'(chan_value), 0);

    // R10 address-zero flag
    set_addr(0); #1;
    chk(addr_zero == 1, "R10 zero", int'(addr_zero), 1);
    set_addr(256); #1;
    chk(addr_zero == 0, "R10 nonzero", int'(addr_zero), 0);

    // R5 R7 sweep of low addresses
    for (int a = 1; a <= 64; a++) begin
      set_addr(a);
      expect_capture("R5 sweep", a, a + 2, a);
    end
    // R7 top of range, both switch groups
    for (int a = 509; a <= 511; a++) begin
      set_addr(a);
      expect_capture("R7 high address", a, 512, a);
    end

    // R6 lower slots and later slots keep value; strobe count checked in expect
    set_addr(10);
    expect_capture("R6 one capture", 10, 40, 3);

    // R4 bad start code
    packet(20, 8'h17, 4);
    chk(stb_cnt == 0, "R4 bad start code", stb_cnt, 0);
    chk(chan_value == slot_val(10, 3), "R4 value kept", int'(chan_value), int'(slot_val(10, 3)));
    expect_capture("R4 recover", 10, 12, 5);

    // R2 overrun mid-packet
    set_addr(5);
    stb_cnt = 0;
    send_break();
    send(8'h00, 0, 0);
    send(slot_val(1, 6), 0, 0);
    send(8'h33, 0, 1);
    for (int s = 3; s <= 8; s++) send(slot_val(s, 6), 0, 0);
    chk(stb_cnt == 0, "R2 overrun ignores", stb_cnt, 0);
    // R2 framing+overrun together is not a break
    send(8'h00, 1, 1);
    send(8'h00, 0, 0);
    for (int s = 1; s <= 8; s++) send(slot_val(s, 7), 0, 0);
    chk(stb_cnt == 0, "R2 ovr over ferr", stb_cnt, 0);
    chk(led == (((breaks % 32) < 16) ? 1'b1 : 1'b0), "R2 led unchanged", int'(led),
        ((breaks % 32) < 16) ? 1 : 0);
    expect_capture("R2 recover", 5, 8, 8);

    // R3 break byte data ignored, counting restarts mid-packet
    set_addr(4);
    stb_cnt = 0;
    send_break(); send(8'h00, 0, 0); send(slot_val(1, 9), 0, 0);
    expect_capture("R3 restart", 4, 6, 9);

    // R7 switch change inside packet takes effect at next break
    set_addr(6);
    stb_cnt = 0;
    send_break(); send(8'h00, 0, 0);
    set_addr(3);
    for (int s = 1; s <= 8; s++) send(slot_val(s, 10), 0, 0);
    chk(stb_cnt == 1, "R7 mid-packet", stb_cnt, 1);
    chk(stb_val == slot_val(6, 10), "R7 mid-packet value", int'(stb_val), int'(slot_val(6, 10)));
    expect_capture("R7 reload", 3, 8, 11);

    // R11 address 0 never captures
    set_addr(0);
    packet(10, 8'h00, 12);
    chk(stb_cnt == 0, "R11 address zero", stb_cnt, 0);

    // R8 long packet
    set_addr(3);
    expect_capture("R8 long packet", 3, 1100, 13);
    expect_capture("R8 after long", 3, 5, 14);

    // R9 more breaks to pass the wrap at 32
    for (int i = 0; i < 40; i++) send_break();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule